// File: doc/BRIEF.md
# On-Screen Display Window Timing Generator

This block places on-screen display characters on a video raster. It takes already conditioned horizontal and vertical sync pulses and a dot clock. It brings both pulses into the clock domain and finds their rising edges. From these edges it keeps a line count relative to the start of the frame and a dot count relative to the start of the line. When both counts fall inside a programmed rectangle, it passes a glyph pixel to three active-high colour outputs and one active-high blanking output. A video mixer downstream uses these outputs to key characters over the picture.

The window is set by four configuration values: first line, height in lines, first dot and width in dots. These values are copied into working registers only at a vertical sync edge, so a write never changes the window partway through a frame. A 3-bit colour code picks one of five colours for menu glyphs. A source select chooses either menu glyphs or caption glyphs, never both. Caption glyphs are always drawn in white.

Top module: `osd_window_gen`

## Requirements
- R1: While reset is held, and after reset until the first vertical sync edge has loaded a window, all four outputs are low.
- R2: Each sync input passes through two synchronising flops, and only its rising edge acts. A sync input that rises before clock edge k acts on the counters at clock edge k+2.
- R3: A vertical edge clears the line count to 0. A horizontal edge that comes without a vertical edge adds one to the line count, which saturates at 2^LINE_W-1. When both edges come together, the vertical edge wins.
- R4: A horizontal edge clears the dot count to 0. On every other clock the dot count adds one and saturates at 2^DOT_W-1.
- R5: The window covers line counts from first line up to (first line + height - 1) and dot counts from first dot up to (first dot + width - 1). The sums are formed without wrap-around. Outside the window all outputs are low.
- R6: The menu colour code gives {r,g,b} as follows: 0 gives green 010, 1 gives red 100, 2 gives white 111, 3 gives yellow 110 and 4 gives cyan 011. Codes 5 to 7 give no output.
- R7: The outputs are registered. The values after clock edge k come from the counts before edge k and from the pixel, colour and select inputs sampled at edge k. Blank is high exactly when any colour output is high.
- R8: With the caption select high, cap_pix is drawn in white and menu_pix has no effect. With it low, menu_pix is drawn in the menu colour and cap_pix has no effect.
- R9: First line, height, first dot and width are taken only at a vertical sync edge. Changes between those edges do not alter the window in the current frame.
- R10: The colour code and the source select take effect on the next output update, without waiting for a vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Conditioned horizontal sync, active high |
| vsync_in | input | 1 | Conditioned vertical sync, active high |
| cfg_line_start | input | LINE_W | First line of the window |
| cfg_height | input | LINE_W | Window height in lines |
| cfg_dot_start | input | DOT_W | First dot of the window |
| cfg_width | input | DOT_W | Window width in dots |
| cfg_colour | input | 3 | Menu colour code |
| cfg_cap_sel | input | 1 | 1 selects caption glyphs, 0 selects menu glyphs |
| menu_pix | input | 1 | Menu glyph pixel for the current dot |
| cap_pix | input | 1 | Caption glyph pixel for the current dot |
| r_out | output | 1 | Red character output |
| g_out | output | 1 | Green character output |
| b_out | output | 1 | Blue character output |
| blank_out | output | 1 | Blanking output |

## Verification
A wrong dot count moves or clips the character rectangle sideways. This shows at the ports on the first window dot of the next line, or of the line where it went wrong. A wrong line count, or a shadow value taken at the wrong time, moves the rectangle up or down. This can stay hidden until the outputs reach the window's first or last line, which may be up to a frame later. A bad colour decode or bad source steering shows on the first lit pixel after it happens, with the wrong {r,g,b} code. For these reasons the bench compares all four outputs on every clock against a behavioural model, over frames that cross every window edge, the dot-count saturation point and edges that arrive together.

// File: rtl/osd_window_gen.sv
module osd_window_gen #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic [LINE_W-1:0] cfg_line_start,
  input  logic [LINE_W-1:0] cfg_height,
  input  logic [DOT_W-1:0]  cfg_dot_start,
  input  logic [DOT_W-1:0]  cfg_width,
  input  logic [2:0]        cfg_colour,
  input  logic              cfg_cap_sel,
  input  logic              menu_pix,
  input  logic              cap_pix,
  output logic              r_out,
  output logic              g_out,
  output logic              b_out,
  output logic              blank_out
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [DOT_W-1:0]  DOT_MAX  = '1;

  logic [2:0] hs_q, vs_q;
  logic h_rise, v_rise;
  logic [LINE_W-1:0] line_cnt, sh_line_start, sh_height;
  logic [DOT_W-1:0]  dot_cnt, sh_dot_start, sh_width;
  logic line_in, dot_in, in_win;
  logic [2:0] menu_rgb, pix_rgb, rgb_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_q <= '0;
      vs_q <= '0;
    end else begin
      hs_q <= {hs_q[1:0], hsync_in};
      vs_q <= {vs_q[1:0], vsync_in};
    end

  assign h_rise = hs_q[1] & ~hs_q[2];
  assign v_rise = vs_q[1] & ~vs_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_cnt      <= '0;
      dot_cnt       <= '0;
      sh_line_start <= '0;
      sh_height     <= '0;
      sh_dot_start  <= '0;
      sh_width      <= '0;
    end else begin
      if (v_rise) begin
        line_cnt      <= '0;
        sh_line_start <= cfg_line_start;
        sh_height     <= cfg_height;
        sh_dot_start  <= cfg_dot_start;
        sh_width      <= cfg_width;
      end else if (h_rise && line_cnt != LINE_MAX) begin
        line_cnt <= line_cnt + 1'b1;
      end
      if (h_rise)
        dot_cnt <= '0;
      else if (dot_cnt != DOT_MAX)
        dot_cnt <= dot_cnt + 1'b1;
    end

  assign line_in = ({1'b0, line_cnt} >= {1'b0, sh_line_start}) &&
                   ({1'b0, line_cnt} <  {1'b0, sh_line_start} + {1'b0, sh_height});
  assign dot_in  = ({1'b0, dot_cnt} >= {1'b0, sh_dot_start}) &&
                   ({1'b0, dot_cnt} <  {1'b0, sh_dot_start} + {1'b0, sh_width});
  assign in_win  = line_in && dot_in;

  always_comb
    case (cfg_colour)
      3'd0:    menu_rgb = 3'b010;
      3'd1:    menu_rgb = 3'b100;
      3'd2:    menu_rgb = 3'b111;
      3'd3:    menu_rgb = 3'b110;
      3'd4:    menu_rgb = 3'b011;
      default: menu_rgb = 3'b000;
    endcase

  assign pix_rgb = cfg_cap_sel ? {3{cap_pix}} : (menu_pix ? menu_rgb : 3'b000);
  assign rgb_nxt = in_win ? pix_rgb : 3'b000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {r_out, g_out, b_out} <= '0;
      blank_out             <= 1'b0;
    end else begin
      {r_out, g_out, b_out} <= rgb_nxt;
      blank_out             <= |rgb_nxt;
    end
endmodule

module osd_window_gen_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              r_out,
  input logic              g_out,
  input logic              b_out,
  input logic              blank_out,
  input logic              cfg_cap_sel,
  input logic              v_rise,
  input logic [LINE_W-1:0] sh_line_start,
  input logic [LINE_W-1:0] sh_height
);
  // R7
  blank_follows_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_out == (r_out || g_out || b_out));
  // R6
  colour_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_out |-> g_out);
  // R8
  caption_white_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_out && $past(cfg_cap_sel)) |-> (r_out && g_out && b_out));
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_rise |=> ($stable(sh_line_start) && $stable(sh_height)));
  // R5
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_height == '0) |=> !blank_out);
endmodule

bind osd_window_gen osd_window_gen_chk #(.LINE_W(LINE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .r_out(r_out), .g_out(g_out), .b_out(b_out),
  .blank_out(blank_out), .cfg_cap_sel(cfg_cap_sel), .v_rise(v_rise),
  .sh_line_start(sh_line_start), .sh_height(sh_height));

// File: tb/osd_window_gen_tb.sv
module osd_window_gen_tb_top;
  localparam int LMAX = 1023;
  localparam int DMAX = 1023;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync_in = 0, vsync_in = 0, cfg_cap_sel = 0, menu_pix = 0, cap_pix = 0;
  logic [9:0] cfg_line_start = 0, cfg_height = 5, cfg_dot_start = 0, cfg_width = 50;
  logic [2:0] cfg_colour = 2;
  logic r_out, g_out, b_out, blank_out;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  osd_window_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .cfg_line_start(cfg_line_start), .cfg_height(cfg_height),
    .cfg_dot_start(cfg_dot_start), .cfg_width(cfg_width),
    .cfg_colour(cfg_colour), .cfg_cap_sel(cfg_cap_sel),
    .menu_pix(menu_pix), .cap_pix(cap_pix),
    .r_out(r_out), .g_out(g_out), .b_out(b_out), .blank_out(blank_out));

  // reference model
  int hq[$], vq[$];
  int m_line, m_dot, s_ls, s_h, s_ds, s_w;
  int exp_rgb, exp_blank;

  function automatic int colour_of(int code);
    case (code)
      0: return 2;   // green 010
      1: return 4;   // red 100
      2: return 7;   // white 111
      3: return 6;   // yellow 110
      4: return 3;   // cyan 011
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hq = {0, 0, 0}; vq = {0, 0, 0};
      m_line = 0; m_dot = 0; s_ls = 0; s_h = 0; s_ds = 0; s_w = 0;
      exp_rgb = 0; exp_blank = 0;
    end else begin
      int hr, vr, pix, rgb;
      bit win;
      hq.push_front(int'(hsync_in)); vq.push_front(int'(vsync_in));
      hr = (hq[2] == 1 && hq[3] == 0) ? 1 : 0;
      vr = (vq[2] == 1 && vq[3] == 0) ? 1 : 0;
      void'(hq.pop_back()); void'(vq.pop_back());
      win = (m_line >= s_ls) && (m_line < s_ls + s_h) &&
            (m_dot >= s_ds) && (m_dot < s_ds + s_w);
      if (cfg_cap_sel) begin pix = int'(cap_pix); rgb = 7; end
      else begin pix = int'(menu_pix); rgb = colour_of(int'(cfg_colour)); end
      exp_rgb = (win && pix == 1) ? rgb : 0;
      exp_blank = (exp_rgb != 0) ? 1 : 0;
      if (vr == 1) begin
        m_line = 0;
        s_ls = int'(cfg_line_start); s_h = int'(cfg_height);
        s_ds = int'(cfg_dot_start); s_w = int'(cfg_width);
      end else if (hr == 1 && m_line < LMAX) m_line++;
      if (hr == 1) m_dot = 0;
      else if (m_dot < DMAX) m_dot++;
    end
  end

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({cur_req, " rgb"}, int'({r_out, g_out, b_out}), exp_rgb);
    check({cur_req, " R7 blank"}, int'(blank_out), exp_blank);
  end

  task automatic tick(bit hs, bit vs, bit toggle_sel);
    @(negedge clk);
    hsync_in = hs; vsync_in = vs;
    menu_pix = 1'($urandom); cap_pix = 1'($urandom);
    if (toggle_sel) cfg_cap_sel = ~cfg_cap_sel;
  endtask

  task automatic do_line(int dots, bit vs, bit toggle_sel);
    for (int i = 0; i < dots; i++) tick(i < 2, vs && i < 2, toggle_sel);
  endtask

  task automatic do_frame(int lines, int dots, bit cycle_colour, bit toggle_sel);
    for (int l = 0; l < lines; l++) begin
      if (cycle_colour) cfg_colour = 3'(l % 8);
      do_line(dots, l == 0, toggle_sel);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    menu_pix = 1; cap_pix = 1;
    repeat (3) @(negedge clk);
    // R1: outputs low under reset
    check("R1 reset rgb", int'({r_out, g_out, b_out}), 0);
    check("R1 reset blank", int'(blank_out), 0);
    rst_n = 1;
    repeat (6) begin
      @(negedge clk);
      // R1: no window loaded before first vertical edge
      check("R1 pre-vsync blank", int'(blank_out), 0);
    end

    cur_req = "R2/R3/R4/R5/R6";
    cfg_line_start = 2; cfg_height = 4; cfg_dot_start = 5; cfg_width = 20;
    do_frame(10, 40, 1, 0);
    do_frame(10, 40, 1, 0);

    cur_req = "R8/R10";
    cfg_colour = 1;
    do_frame(10, 40, 0, 1);
    cfg_cap_sel = 0;

    cur_req = "R9";
    for (int l = 0; l < 10; l++) begin
      if (l == 3) begin
        cfg_line_start = 1; cfg_height = 8; cfg_dot_start = 0; cfg_width = 39;
      end
      cfg_colour = 3'(l % 5);
      do_line(40, l == 0, 0);
    end
    do_frame(10, 40, 1, 0);

    cur_req = "R4 saturation/R5";
    cfg_line_start = 0; cfg_height = 2; cfg_dot_start = 1020; cfg_width = 3;
    do_frame(3, 1100, 0, 0);

    cur_req = "R3 lone vsync";
    cfg_line_start = 0; cfg_height = 3; cfg_dot_start = 0; cfg_width = 30;
    do_frame(4, 40, 0, 0);
    for (int i = 0; i < 10; i++) tick(0, i >= 3 && i < 5, 0);
    do_line(40, 0, 0);
    do_line(40, 0, 0);

    cur_req = "R5 window edges";
    cfg_line_start = 0; cfg_height = 1023; cfg_dot_start = 0; cfg_width = 1023;
    cfg_colour = 4;
    do_frame(4, 40, 0, 0);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule